// File: doc/BRIEF.md
# Receive Sample Router and Channel Packer

This block sits between four receive converters and up to four downconverter channels. Every converter sample is held in its own register whenever its strobe pulses. A single 32-bit control word chooses which held sample feeds the in-phase input of each channel and which feeds its quadrature input. One flag in that word forces all quadrature inputs to zero, which suits real-only signal paths.

The downconverter results come back as eight 16-bit words. When the result strobe pulses, the packer captures them and serializes the configured number of complex channels onto a valid/ready word stream, ready for a host link. The channel count may be 1, 2 or 4, giving 2, 4 or 8 words per frame.

The packer is a two-state machine:
- `PK_IDLE` waits for a result strobe. The *accept* transition moves it to `PK_SEND` when the strobe arrives while the sink is ready.
- `PK_SEND` presents one word per handshake. The *last-handshake* transition returns it to `PK_IDLE` once the final word of the frame is taken.
- In every other case each state holds.

Frames that cannot be accepted are dropped whole and counted. Control updates are staged and only take effect while the packer is idle.

Top module: `rx_route_pack`

## Requirements
- R1: A write with `reg_addr` equal to 38 loads the control word. Writes to any other address leave it unchanged. `reg_rdata` returns the stored word with bits [31:20] always zero. The field layout is: bits [2:0] channel count, bit 3 Q-zero flag, and for channel c the I select at bits [5+4c:4+4c] and the Q select at bits [7+4c:6+4c].
- R2: A channel's I select value k (0..3) drives that channel's `ddc_in_i` slice (bits [16c+15:16c]) with the held sample of converter k.
- R3: When bit 3 is 0, a channel's Q select value k drives its `ddc_in_q` slice with the held sample of converter k.
- R4: When bit 3 is 1, every `ddc_in_q` slice is zero whatever the Q selects hold, and the I routing is unaffected.
- R5: Converter k's held sample (input bits [16k+15:16k]) updates only in a cycle where `adc_stb[k]` is 1. Otherwise it keeps its value.
- R6: A frame for channel count N (1, 2 or 4) is 2N words in the order I0, Q0, I1, Q1 and so on. I words come from `res_i` slices and Q words from `res_q` slices.
- R7: A channel count of 0, 3, 5, 6 or 7 is packed as one channel, and `cfg_bad` is 1 while such a value is stored.
- R8: A control write made during a frame does not alter that frame. The new value governs the next frame.
- R9: A result strobe that arrives while a frame is in progress, or while `word_ready` is 0 in idle, drops that frame whole and increments `overrun_cnt` by one.
- R10: While `word_valid` is 1 and `word_ready` is 0, `word_data` and `word_valid` hold.
- R11: After reset, `reg_rdata` is 1 (all selects 0, Q-zero 0, count 1), `word_valid` is 0, `overrun_cnt` is 0 and `cfg_bad` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Stored control word, reserved bits zero |
| cfg_bad | output | 1 | Stored channel count is not 1, 2 or 4 |
| adc_data | input | 64 | Four converter samples, converter k at [16k+15:16k] |
| adc_stb | input | 4 | Per-converter sample strobe |
| ddc_in_i | output | 64 | Routed I input per channel |
| ddc_in_q | output | 64 | Routed Q input per channel |
| res_i | input | 64 | Downconverter I results per channel |
| res_q | input | 64 | Downconverter Q results per channel |
| res_stb | input | 1 | Results ready, a frame is due |
| word_data | output | 16 | Packed output word |
| word_valid | output | 1 | Output word valid |
| word_ready | input | 1 | Sink ready |
| overrun_cnt | output | 8 | Count of dropped frames |

## Verification
A control write is seen on `reg_rdata` and `cfg_bad` one edge after the strobe. It reaches the routed outputs one edge later, when the staged word is applied while idle. The bench waits one extra cycle after every write before checking routing. A converter strobe shows on the routed outputs after one edge. A result strobe puts word 0 on the output after one edge, and each later word follows one handshake edge after the one before it. A dropped frame shows up in `overrun_cnt` after one edge. The bench drives every input on the falling edge and samples on the next falling edge, so each check falls exactly one rising edge after its stimulus.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int CNT_W   = 3;
    localparam int QZ_BIT  = 3;
    localparam int SEL_LSB = 4;

    typedef enum logic {
        PK_IDLE = 1'b0,
        PK_SEND = 1'b1
    } pk_state_t;

    function automatic logic cnt_legal(input logic [CNT_W-1:0] f);
        return (f == 3'd1) || (f == 3'd2) || (f == 3'd4);
    endfunction

    function automatic logic [CNT_W-1:0] cnt_eff(input logic [CNT_W-1:0] f);
        return cnt_legal(f) ? f : 3'd1;
    endfunction
endpackage

// File: rtl/rxr_cfg_reg.sv
module rxr_cfg_reg
    import rxr_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int CFG_ADDR = 38,
    parameter int CFG_BITS = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    input  logic                busy,
    output logic [31:0]         rdata,
    output logic [CFG_BITS-1:0] active,
    output logic                bad
);
    localparam logic [CFG_BITS-1:0] RST_VAL = CFG_BITS'(1);

    logic [CFG_BITS-1:0] pend_q;
    logic [CFG_BITS-1:0] act_q;
    logic                unused_wr_hi;

    assign unused_wr_hi = ^wdata[31:CFG_BITS];

    // staged copy written by the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= RST_VAL;
        end else if (wr && (addr == ADDR_W'(CFG_ADDR))) begin
            pend_q <= wdata[CFG_BITS-1:0];
        end
    end

    // applied copy, only refreshed while the packer is idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= RST_VAL;
        end else if (!busy) begin
            act_q <= pend_q;
        end
    end

    assign rdata  = {{(32 - CFG_BITS){1'b0}}, pend_q};
    assign active = act_q;
    assign bad    = !cnt_legal(pend_q[CNT_W-1:0]);

    // R8: no configuration change while a frame is on its way out
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(act_q));
endmodule

// File: rtl/rxr_route.sv
module rxr_route #(
    parameter int NUM_ADC = 4,
    parameter int NUM_CH  = 4,
    parameter int SW      = 16,
    parameter int SELW    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_ADC*SW-1:0]      adc_data,
    input  logic [NUM_ADC-1:0]         adc_stb,
    input  logic                       qz,
    input  logic [2*SELW*NUM_CH-1:0]   sel,
    output logic [NUM_CH*SW-1:0]       ddc_i,
    output logic [NUM_CH*SW-1:0]       ddc_q
);
    logic [SW-1:0] hold_q [NUM_ADC];

    for (genvar k = 0; k < NUM_ADC; k++) begin : g_hold
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q[k] <= '0;
            end else if (adc_stb[k]) begin
                hold_q[k] <= adc_data[k*SW +: SW];
            end
        end

        // R5: a held sample moves only on its own strobe
        a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
            !adc_stb[k] |=> $stable(hold_q[k]));
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic [SELW-1:0] isel;
        logic [SELW-1:0] qsel;
        assign isel = sel[2*SELW*c +: SELW];
        assign qsel = sel[2*SELW*c + SELW +: SELW];
        assign ddc_i[c*SW +: SW] = hold_q[isel];
        assign ddc_q[c*SW +: SW] = qz ? '0 : hold_q[qsel];
    end
endmodule

// File: rtl/rxr_packer.sv
module rxr_packer
    import rxr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int SW     = 16,
    parameter int OVR_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH*SW-1:0] res_i,
    input  logic [NUM_CH*SW-1:0] res_q,
    input  logic                 res_stb,
    input  logic [CNT_W-1:0]     nch,
    input  logic                 out_ready,
    output logic [SW-1:0]        out_data,
    output logic                 out_valid,
    output logic [OVR_W-1:0]     overrun,
    output logic                 busy
);
    localparam int WORDS = 2 * NUM_CH;
    localparam int IDX_W = $clog2(WORDS);

    pk_state_t            state_q, state_d;
    logic [WORDS*SW-1:0]  frame_in, frame_q;
    logic [IDX_W-1:0]     idx_q, last_q;
    logic [CNT_W:0]       two_n;
    logic                 accept, drop, last_hs;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_weave
        assign frame_in[(2*c)*SW   +: SW] = res_i[c*SW +: SW];
        assign frame_in[(2*c+1)*SW +: SW] = res_q[c*SW +: SW];
    end

    assign two_n   = {nch, 1'b0};
    assign accept  = (state_q == PK_IDLE) && res_stb && out_ready;
    assign drop    = res_stb && !accept;
    assign last_hs = (state_q == PK_SEND) && out_ready && (idx_q == last_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PK_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PK_IDLE: if (accept)  state_d = PK_SEND;
            PK_SEND: if (last_hs) state_d = PK_IDLE;
        endcase
    end

    // frame datapath and drop counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            idx_q   <= '0;
            last_q  <= '0;
            overrun <= '0;
        end else begin
            if (accept) begin
                frame_q <= frame_in;
                idx_q   <= '0;
                last_q  <= IDX_W'(two_n - 1'b1);
            end else if ((state_q == PK_SEND) && out_ready) begin
                idx_q <= idx_q + 1'b1;
            end
            if (drop) overrun <= overrun + 1'b1;
        end
    end

    // outputs
    always_comb begin
        out_valid = (state_q == PK_SEND);
        busy      = (state_q != PK_IDLE);
        out_data  = frame_q[idx_q*SW +: SW];
    end

    // R10: stalled word holds
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R9: strobe while busy drops and counts
    a_r9_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (res_stb && busy) |=> (overrun == OVR_W'($past(overrun) + 1'b1)));
    // R6: word index never passes the frame end
    a_r6_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx_q <= last_q));
endmodule

// File: rtl/rx_route_pack.sv
module rx_route_pack
    import rxr_pkg::*;
#(
    parameter int NUM_ADC  = 4,
    parameter int NUM_CH   = 4,
    parameter int SW       = 16,
    parameter int ADDR_W   = 7,
    parameter int CFG_ADDR = 38,
    parameter int OVR_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic                  cfg_bad,
    input  logic [NUM_ADC*SW-1:0] adc_data,
    input  logic [NUM_ADC-1:0]    adc_stb,
    output logic [NUM_CH*SW-1:0]  ddc_in_i,
    output logic [NUM_CH*SW-1:0]  ddc_in_q,
    input  logic [NUM_CH*SW-1:0]  res_i,
    input  logic [NUM_CH*SW-1:0]  res_q,
    input  logic                  res_stb,
    output logic [SW-1:0]         word_data,
    output logic                  word_valid,
    input  logic                  word_ready,
    output logic [OVR_W-1:0]      overrun_cnt
);
    localparam int SELW     = $clog2(NUM_ADC);
    localparam int SEL_BITS = 2 * SELW * NUM_CH;
    localparam int CFG_BITS = SEL_LSB + SEL_BITS;

    logic [CFG_BITS-1:0] active;
    logic [CNT_W-1:0]    nch_eff;
    logic                busy;

    rxr_cfg_reg #(
        .ADDR_W  (ADDR_W),
        .CFG_ADDR(CFG_ADDR),
        .CFG_BITS(CFG_BITS)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .busy  (busy),
        .rdata (reg_rdata),
        .active(active),
        .bad   (cfg_bad)
    );

    rxr_route #(
        .NUM_ADC(NUM_ADC),
        .NUM_CH (NUM_CH),
        .SW     (SW),
        .SELW   (SELW)
    ) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .adc_data(adc_data),
        .adc_stb (adc_stb),
        .qz      (active[QZ_BIT]),
        .sel     (active[CFG_BITS-1:SEL_LSB]),
        .ddc_i   (ddc_in_i),
        .ddc_q   (ddc_in_q)
    );

    assign nch_eff = cnt_eff(active[CNT_W-1:0]);

    rxr_packer #(
        .NUM_CH(NUM_CH),
        .SW    (SW),
        .OVR_W (OVR_W)
    ) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .res_i    (res_i),
        .res_q    (res_q),
        .res_stb  (res_stb),
        .nch      (nch_eff),
        .out_ready(word_ready),
        .out_data (word_data),
        .out_valid(word_valid),
        .overrun  (overrun_cnt),
        .busy     (busy)
    );

    // R7: the packer only ever sees a legal channel count
    a_r7_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(nch_eff));
    // R1: reserved bits never read back set
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[31:CFG_BITS] == '0));
endmodule

// File: tb/tb_rx_route_pack.sv
module tb_rx_route_pack;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [6:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        cfg_bad;
    logic [63:0] adc_data;
    logic [3:0]  adc_stb;
    logic [63:0] ddc_in_i, ddc_in_q;
    logic [63:0] res_i, res_q;
    logic        res_stb;
    logic [15:0] word_data;
    logic        word_valid;
    logic        word_ready;
    logic [7:0]  overrun_cnt;

    int checks = 0;
    int errors = 0;
    int exp_ovr = 0;

    always #5 clk = ~clk;

    rx_route_pack dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_bad(cfg_bad),
        .adc_data(adc_data), .adc_stb(adc_stb), .ddc_in_i(ddc_in_i),
        .ddc_in_q(ddc_in_q), .res_i(res_i), .res_q(res_q), .res_stb(res_stb),
        .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
        .overrun_cnt(overrun_cnt)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkcfg(input logic [2:0] n, input logic qz,
                                          input logic [7:0] isel, input logic [7:0] qsel);
        logic [31:0] v;
        v = '0;
        v[2:0] = n;
        v[3] = qz;
        for (int c = 0; c < 4; c++) begin
            v[4+4*c +: 2] = isel[2*c +: 2];
            v[6+4*c +: 2] = qsel[2*c +: 2];
        end
        return v;
    endfunction

    function automatic logic [15:0] adc_val(input int k);
        return 16'hA000 + 16'(k * 16'h0111);
    endfunction

    function automatic logic [15:0] exp_word(input int k);
        return (k % 2 == 0) ? 16'h1000 + 16'(k / 2) : 16'h2000 + 16'(k / 2);
    endfunction

    task automatic wr_reg(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
    endtask

    // one frame with ready held high; optional write or extra strobe mid-frame
    task automatic run_frame(input int n_words, input string req,
                             input bit inj_wr, input logic [31:0] wval, input bit inj_stb);
        @(negedge clk);
        res_stb = 1'b1;
        for (int k = 0; k < n_words; k++) begin
            @(negedge clk);
            res_stb = 1'b0;
            reg_wr  = 1'b0;
            chk({req, " valid"}, 64'(word_valid), 64'd1);
            chk({req, " word"}, 64'(word_data), 64'(exp_word(k)));
            if (k == 2 && inj_wr) begin
                reg_wr = 1'b1; reg_addr = 7'd38; reg_wdata = wval;
            end
            if (k == 2 && inj_stb) begin
                res_stb = 1'b1;
                exp_ovr++;
            end
        end
        @(negedge clk);
        reg_wr = 1'b0;
        res_stb = 1'b0;
        chk({req, " end of frame"}, 64'(word_valid), 64'd0);
    endtask

    task automatic t_reset;
        chk("R11 rdata", 64'(reg_rdata), 64'd1);
        chk("R11 valid", 64'(word_valid), 64'd0);
        chk("R11 overrun", 64'(overrun_cnt), 64'd0);
        chk("R11 cfg_bad", 64'(cfg_bad), 64'd0);
    endtask

    task automatic t_reg_access;
        wr_reg(7'd38, 32'hFFF0_0012);
        chk("R1 reserved masked", 64'(reg_rdata), 64'h12);
        wr_reg(7'd5, 32'h0000_0003);
        chk("R1 other address ignored", 64'(reg_rdata), 64'h12);
        chk("R1 cfg_bad after ignored write", 64'(cfg_bad), 64'd0);
    endtask

    task automatic t_capture;
        wr_reg(7'd38, mkcfg(3'd1, 1'b0, 8'h00, 8'h00));
        @(negedge clk);
        for (int k = 0; k < 4; k++) adc_data[16*k +: 16] = adc_val(k);
        adc_stb = 4'hF;
        @(negedge clk);
        adc_stb = 4'h0;
        adc_data = 64'h5555_5555_5555_5555;
        chk("R5 captured on strobe", 64'(ddc_in_i[15:0]), 64'(adc_val(0)));
        @(negedge clk);
        chk("R5 held without strobe", 64'(ddc_in_i[15:0]), 64'(adc_val(0)));
        adc_data[16 +: 16] = 16'h7777;
        adc_stb = 4'b0010;
        @(negedge clk);
        adc_stb = 4'h0;
        wr_reg(7'd38, mkcfg(3'd1, 1'b0, 8'b00_00_01_00, 8'h00));
        chk("R5 single strobe updates one", 64'(ddc_in_i[31:16]), 64'h7777);
        chk("R5 single strobe leaves others", 64'(ddc_in_i[15:0]), 64'(adc_val(0)));
        @(negedge clk);
        for (int k = 0; k < 4; k++) adc_data[16*k +: 16] = adc_val(k);
        adc_stb = 4'hF;
        @(negedge clk);
        adc_stb = 4'h0;
    endtask

    task automatic t_route(input logic qz);
        logic [7:0] is, qs;
        is = {2'd0, 2'd1, 2'd2, 2'd3};
        qs = {2'd3, 2'd3, 2'd0, 2'd1};
        wr_reg(7'd38, mkcfg(3'd1, qz, is, qs));
        for (int c = 0; c < 4; c++) begin
            chk("R2 I routing", 64'(ddc_in_i[16*c +: 16]), 64'(adc_val(int'(is[2*c +: 2]))));
            if (qz)
                chk("R4 Q forced zero", 64'(ddc_in_q[16*c +: 16]), 64'd0);
            else
                chk("R3 Q routing", 64'(ddc_in_q[16*c +: 16]), 64'(adc_val(int'(qs[2*c +: 2]))));
        end
    endtask

    task automatic t_frames;
        wr_reg(7'd38, mkcfg(3'd1, 1'b0, 8'h00, 8'h00));
        run_frame(2, "R6 one channel", 1'b0, 32'd0, 1'b0);
        wr_reg(7'd38, mkcfg(3'd2, 1'b0, 8'h00, 8'h00));
        run_frame(4, "R6 two channels", 1'b0, 32'd0, 1'b0);
        wr_reg(7'd38, mkcfg(3'd4, 1'b0, 8'h00, 8'h00));
        run_frame(8, "R6 four channels", 1'b0, 32'd0, 1'b0);
    endtask

    task automatic t_bad_count;
        wr_reg(7'd38, mkcfg(3'd3, 1'b0, 8'h00, 8'h00));
        chk("R7 cfg_bad for 3", 64'(cfg_bad), 64'd1);
        run_frame(2, "R7 count 3 packs one", 1'b0, 32'd0, 1'b0);
        wr_reg(7'd38, mkcfg(3'd0, 1'b0, 8'h00, 8'h00));
        chk("R7 cfg_bad for 0", 64'(cfg_bad), 64'd1);
        run_frame(2, "R7 count 0 packs one", 1'b0, 32'd0, 1'b0);
        wr_reg(7'd38, mkcfg(3'd2, 1'b0, 8'h00, 8'h00));
        chk("R7 cfg_bad clears", 64'(cfg_bad), 64'd0);
    endtask

    task automatic t_stall;
        wr_reg(7'd38, mkcfg(3'd2, 1'b0, 8'h00, 8'h00));
        @(negedge clk);
        res_stb = 1'b1;
        @(negedge clk);
        res_stb = 1'b0;
        chk("R10 first word", 64'(word_data), 64'(exp_word(0)));
        word_ready = 1'b0;
        for (int s = 0; s < 2; s++) begin
            @(negedge clk);
            chk("R10 stalled valid", 64'(word_valid), 64'd1);
            chk("R10 stalled data", 64'(word_data), 64'(exp_word(0)));
        end
        word_ready = 1'b1;
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            chk("R10 resumed word", 64'(word_data), 64'(exp_word(k)));
        end
        @(negedge clk);
        chk("R10 frame end", 64'(word_valid), 64'd0);
    endtask

    task automatic t_drop;
        @(negedge clk);
        word_ready = 1'b0;
        res_stb = 1'b1;
        exp_ovr++;
        @(negedge clk);
        res_stb = 1'b0;
        word_ready = 1'b1;
        chk("R9 idle not ready drops", 64'(overrun_cnt), 64'(exp_ovr));
        chk("R9 no frame started", 64'(word_valid), 64'd0);
        wr_reg(7'd38, mkcfg(3'd4, 1'b0, 8'h00, 8'h00));
        run_frame(8, "R9 busy strobe", 1'b0, 32'd0, 1'b1);
        chk("R9 busy drop counted", 64'(overrun_cnt), 64'(exp_ovr));
    endtask

    task automatic t_apply;
        wr_reg(7'd38, mkcfg(3'd4, 1'b0, 8'h00, 8'h00));
        run_frame(8, "R8 frame unchanged", 1'b1, mkcfg(3'd1, 1'b0, 8'h00, 8'h00), 1'b0);
        chk("R8 write stored", 64'(reg_rdata), 64'd1);
        run_frame(2, "R8 next frame uses new count", 1'b0, 32'd0, 1'b0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        adc_data = '0; adc_stb = '0; res_stb = 1'b0; word_ready = 1'b1;
        for (int c = 0; c < 4; c++) begin
            res_i[16*c +: 16] = 16'h1000 + 16'(c);
            res_q[16*c +: 16] = 16'h2000 + 16'(c);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reg_access();
        t_capture();
        t_route(1'b0);
        t_route(1'b1);
        t_frames();
        t_bad_count();
        t_stall();
        t_drop();
        t_apply();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule